// File: doc/BRIEF.md
# Page-Based Memory Write Protector

This block guards every core-memory write against a protection map of one bit per 256-word page. It covers a 64K-word address space, so the map has 256 bits. The map is held in sixteen 16-bit protection registers. Each register is loaded whole from the accumulator by a direct-write operation, which gives a register select and the accumulator value. When a write request arrives, the block looks up the bit for the target page. If the bit is set and the running program is not itself protected, the memory write enable is withheld and a violation pulse follows.

The same map is also looked up at the current instruction address. That result is the protected-program status indicator. A protected program may write to any page. Reset clears the whole map, so memory starts out unprotected. Both address inputs carry only the page number, which is address bits [15:8]. The offset within a page has no bearing on protection.

Top module: `pgprot_guard`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears all 256 map bits and the violation output. Afterwards every write request passes and prog_protected is 0.
- R2: When map_ld_en is 1 at a rising clock edge, register map_ld_sel takes the value of acc_data. A lookup made in the same cycle as a load still sees the old contents. The new contents apply from the next cycle.
- R3: The page number is address bits [15:8]. Its upper four bits [15:12] choose the protection register, and its lower four bits [11:8] choose the bit within that register. Bit 0 of register 0 guards page 0x00, and bit 15 of register 15 guards page 0xFF.
- R4: prog_protected is 1 exactly when the map bit for pc_page is 1. It responds in the same cycle.
- R5: A write request (wr_req=1) to a page whose map bit is 0 passes: mem_wr_en=1 and wr_blocked=0 in the same cycle.
- R6: A write request to a page whose map bit is 1 is blocked when prog_protected is 0: mem_wr_en=0 and wr_blocked=1 in the same cycle.
- R7: While prog_protected is 1, every write request passes, whatever its page's map bit.
- R8: violation is 1 in the cycle after a blocked request, and 0 in every other cycle.
- R9: With wr_req=0, mem_wr_en and wr_blocked stay 0 whatever the page and map.
- R10: Loading one protection register leaves the other fifteen unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_ld_en | input | 1 | Direct-write strobe that loads one protection register |
| map_ld_sel | input | 4 | Number of the protection register to load (0 to 15) |
| acc_data | input | 16 | Accumulator value that is loaded into the selected register |
| pc_page | input | 8 | Page of the current instruction address (address bits [15:8]) |
| wr_req | input | 1 | Memory write request |
| wr_page | input | 8 | Page of the write address (address bits [15:8]) |
| prog_protected | output | 1 | Protected-program status indicator |
| mem_wr_en | output | 1 | Write enable passed on to memory |
| wr_blocked | output | 1 | The current request is refused |
| violation | output | 1 | One-cycle pulse after each refused request |

## Verification
The bench first applies single-bit maps. Placing one set bit near the edges of its register (bits 0 and 15) and probing the neighbouring pages separates a correct page decode from one that swaps or shifts the register select and the bit select. It then loads every register with a distinct pattern and sweeps all 256 write pages, with instruction pages that are sometimes protected and sometimes not. This separates the blocked case from the case where a protected program writes freely.

Further sequences load the map in the same cycle as a lookup, issue back-to-back refused requests, hold requests off over protected pages, and apply reset in the middle of a run. These show the load timing, the pulse shape of violation, that requests are gated, and that reset clears the map.

// File: rtl/pgprot_pkg.sv
package pgprot_pkg;

  // Outcome of a single write check
  typedef enum logic [1:0] {
    VERDICT_IDLE  = 2'd0,
    VERDICT_PASS  = 2'd1,
    VERDICT_BLOCK = 2'd2
  } verdict_e;

endpackage

// File: rtl/pgprot_map.sv
// Bank of protection registers, each loaded whole from the accumulator.
module pgprot_map #(
  parameter int REG_W    = 16,
  parameter int NUM_REGS = 16,
  parameter int SEL_W    = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ld_en,
  input  logic [SEL_W-1:0]          ld_sel,
  input  logic [REG_W-1:0]          ld_data,
  output logic [NUM_REGS*REG_W-1:0] map_flat
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic             hit;
    logic [REG_W-1:0] q_r;
    logic [REG_W-1:0] d_c;

    assign hit = ld_en && (ld_sel == SEL_W'(g));

    always_comb begin
      d_c = q_r;
      if (hit) d_c = ld_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q_r <= '0;
      else if (hit) q_r <= d_c;
    end

    assign map_flat[g*REG_W +: REG_W] = q_r;
  end

endmodule

// File: rtl/pgprot_lookup.sv
// Selects the map bit that guards one page.
module pgprot_lookup #(
  parameter int PAGE_W   = 8,
  parameter int REG_W    = 16,
  parameter int NUM_REGS = 16
) (
  input  logic [NUM_REGS*REG_W-1:0] map_flat,
  input  logic [PAGE_W-1:0]         page,
  output logic                      prot
);

  localparam int BIT_W = $clog2(REG_W);
  localparam int SEL_W = PAGE_W - BIT_W;

  logic [SEL_W-1:0]  reg_idx;
  logic [BIT_W-1:0]  bit_idx;
  logic [PAGE_W-1:0] flat_idx;

  always_comb begin
    reg_idx  = page[PAGE_W-1 -: SEL_W];
    bit_idx  = page[BIT_W-1:0];
    flat_idx = {reg_idx, bit_idx};
    prot     = map_flat[flat_idx];
  end

endmodule

// File: rtl/pgprot_judge.sv
// Decides pass or block for a write request and times the violation pulse.
module pgprot_judge
  import pgprot_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_req,
  input  logic     page_prot,
  input  logic     prog_prot,
  output verdict_e verdict,
  output logic     mem_wr_en,
  output logic     wr_blocked,
  output logic     violation
);

  logic viol_d;
  logic viol_q;

  always_comb begin
    if (!wr_req)                       verdict = VERDICT_IDLE;
    else if (page_prot && !prog_prot)  verdict = VERDICT_BLOCK;
    else                               verdict = VERDICT_PASS;
    mem_wr_en  = (verdict == VERDICT_PASS);
    wr_blocked = (verdict == VERDICT_BLOCK);
    viol_d     = wr_blocked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) viol_q <= 1'b0;
    else        viol_q <= viol_d;
  end

  assign violation = viol_q;

endmodule

// File: rtl/pgprot_guard.sv
module pgprot_guard
  import pgprot_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int REG_W  = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 map_ld_en,
  input  logic [$clog2((1<<PAGE_W)/REG_W)-1:0] map_ld_sel,
  input  logic [REG_W-1:0]                     acc_data,
  input  logic [PAGE_W-1:0]                    pc_page,
  input  logic                                 wr_req,
  input  logic [PAGE_W-1:0]                    wr_page,
  output logic                                 prog_protected,
  output logic                                 mem_wr_en,
  output logic                                 wr_blocked,
  output logic                                 violation
);

  localparam int NUM_REGS = (1 << PAGE_W) / REG_W;
  localparam int SEL_W    = $clog2(NUM_REGS);

  logic [NUM_REGS*REG_W-1:0] map_flat;
  logic                      pc_prot;
  logic                      wr_prot;
  verdict_e                  verdict;

  pgprot_map #(.REG_W(REG_W), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_en    (map_ld_en),
    .ld_sel   (map_ld_sel),
    .ld_data  (acc_data),
    .map_flat (map_flat)
  );

  pgprot_lookup #(.PAGE_W(PAGE_W), .REG_W(REG_W), .NUM_REGS(NUM_REGS)) u_pc_look (
    .map_flat (map_flat),
    .page     (pc_page),
    .prot     (pc_prot)
  );

  pgprot_lookup #(.PAGE_W(PAGE_W), .REG_W(REG_W), .NUM_REGS(NUM_REGS)) u_wr_look (
    .map_flat (map_flat),
    .page     (wr_page),
    .prot     (wr_prot)
  );

  pgprot_judge u_judge (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_req     (wr_req),
    .page_prot  (wr_prot),
    .prog_prot  (pc_prot),
    .verdict    (verdict),
    .mem_wr_en  (mem_wr_en),
    .wr_blocked (wr_blocked),
    .violation  (violation)
  );

  assign prog_protected = pc_prot;

endmodule

// File: rtl/pgprot_guard_chk.sv
module pgprot_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_req,
  input logic prog_protected,
  input logic mem_wr_en,
  input logic wr_blocked,
  input logic violation
);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req |-> (!mem_wr_en && !wr_blocked));

  p_request_resolves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (mem_wr_en != wr_blocked));

  p_block_needs_unprot_prog_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |-> (!mem_wr_en && !prog_protected));

  p_protected_prog_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && prog_protected) |-> mem_wr_en);

  p_violation_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> violation);

  p_violation_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    violation |-> $past(wr_blocked));

endmodule

bind pgprot_guard pgprot_guard_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wr_req         (wr_req),
  .prog_protected (prog_protected),
  .mem_wr_en      (mem_wr_en),
  .wr_blocked     (wr_blocked),
  .violation      (violation)
);

// File: tb/test_pgprot_guard.sv
`timescale 1ns/1ps
module test_pgprot_guard;

  logic       clk;
  logic       rst_n;
  logic       map_ld_en;
  logic [3:0] map_ld_sel;
  logic [15:0] acc_data;
  logic [7:0] pc_page;
  logic       wr_req;
  logic [7:0] wr_page;
  logic       prog_protected;
  logic       mem_wr_en;
  logic       wr_blocked;
  logic       violation;

  int n_checks = 0;
  int n_fails  = 0;

  logic [15:0] mdl [16];
  logic        viol_exp;

  pgprot_guard i_pgprot_guard (
    .clk(clk), .rst_n(rst_n), .map_ld_en(map_ld_en), .map_ld_sel(map_ld_sel),
    .acc_data(acc_data), .pc_page(pc_page), .wr_req(wr_req), .wr_page(wr_page),
    .prog_protected(prog_protected), .mem_wr_en(mem_wr_en),
    .wr_blocked(wr_blocked), .violation(violation)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic mdl_bit(input logic [7:0] pg);
    return mdl[pg[7:4]][pg[3:0]];
  endfunction

  task automatic chk(input string ph, input string rq, input logic act, input logic exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s [%s] %s: actual %b expected %b", rq, ph, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare after settling, update the model at posedge.
  task automatic step(input string ph, input bit ld, input int sel, input logic [15:0] d,
                      input bit req, input logic [7:0] wp, input logic [7:0] pp);
    logic e_prot, e_blk, e_en;
    string rq;
    @(negedge clk);
    map_ld_en = ld; map_ld_sel = sel[3:0]; acc_data = d;
    wr_req = req; wr_page = wp; pc_page = pp;
    #5;
    e_prot = mdl_bit(pp);
    e_blk  = req && mdl_bit(wp) && !e_prot;
    e_en   = req && !e_blk;
    if (!req)            rq = "R9";
    else if (e_prot)     rq = "R7";
    else if (mdl_bit(wp)) rq = "R6";
    else                 rq = "R5";
    chk(ph, "R4", prog_protected, e_prot, "prog_protected");
    chk(ph, rq,   mem_wr_en,      e_en,   "mem_wr_en");
    chk(ph, rq,   wr_blocked,     e_blk,  "wr_blocked");
    chk(ph, "R8", violation,      viol_exp, "violation");
    @(posedge clk);
    if (ld) mdl[sel] = d;
    viol_exp = e_blk;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    map_ld_en = 0; map_ld_sel = 0; acc_data = 0; wr_req = 0; wr_page = 0; pc_page = 0;
    for (int i = 0; i < 16; i++) mdl[i] = 16'h0000;
    viol_exp = 1'b0;
    #5;
    chk("reset", "R1", violation, 1'b0, "violation in reset");
    chk("reset", "R1", prog_protected, 1'b0, "prog_protected in reset");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    n_fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b1;
    do_reset();

    // R1: cleared map lets every write through
    for (int p = 0; p < 256; p += 17) step("R1 cleared", 0, 0, 0, 1, 8'(p), 8'(255 - p));

    // R2/R3: single bits at register edges; probe neighbours
    step("R2 load r3", 1, 3, 16'h8001, 1, 8'h30, 8'h00); // same cycle: old map
    step("R2 after load", 0, 0, 0, 1, 8'h30, 8'h00);
    step("R3 bit15", 0, 0, 0, 1, 8'h3F, 8'h00);
    step("R3 neighbour", 0, 0, 0, 1, 8'h31, 8'h00);
    step("R3 swapped", 0, 0, 0, 1, 8'h03, 8'h00);
    step("R3 next reg", 0, 0, 0, 1, 8'h40, 8'h00);
    // R10: load another register, first one intact
    step("R10 load r5", 1, 5, 16'h0010, 0, 8'h00, 8'h00);
    step("R10 r3 kept", 0, 0, 0, 1, 8'h3F, 8'h00);
    step("R10 r5 new", 0, 0, 0, 1, 8'h54, 8'h00);
    // R8: back-to-back blocks then idle
    step("R8 blk1", 0, 0, 0, 1, 8'h30, 8'h01);
    step("R8 blk2", 0, 0, 0, 1, 8'h54, 8'h02);
    step("R8 idle", 0, 0, 0, 0, 8'h30, 8'h02);
    step("R8 idle2", 0, 0, 0, 0, 8'h30, 8'h02);
    // R4/R7: protected program writes anywhere
    step("R7 prot prog", 0, 0, 0, 1, 8'h30, 8'h54);
    step("R7 prot prog", 0, 0, 0, 1, 8'h3F, 8'h30);
    // R9: no request over protected page
    step("R9 no req", 0, 0, 0, 0, 8'h3F, 8'h00);
    // Corner pages 0x00 and 0xFF
    step("R3 load r0", 1, 0, 16'h0001, 0, 8'h00, 8'h00);
    step("R3 load r15", 1, 15, 16'h8000, 1, 8'h00, 8'h00);
    step("R3 page00", 0, 0, 0, 1, 8'h00, 8'h10);
    step("R3 pageFF", 0, 0, 0, 1, 8'hFF, 8'h10);
    step("R4 pc FF", 0, 0, 0, 1, 8'h00, 8'hFF);

    // Full map with distinct patterns, sweep every page
    for (int g = 0; g < 16; g++) step("R2 fill", 1, g, 16'((g * 16'h1357) ^ 16'hA5C3), 0, 8'h00, 8'h00);
    for (int p = 0; p < 256; p++) step("R3 sweep", 0, 0, 0, 1, 8'(p), 8'((p * 37) & 255));
    for (int p = 0; p < 256; p += 3) step("R6 sweep", 0, 0, 0, (p % 5) != 0, 8'(p), 8'h02);

    // R1: reset mid-run after a block clears map and pulse
    step("R1 pre", 0, 0, 0, 1, 8'h00, 8'h02);
    do_reset();
    for (int p = 0; p < 256; p += 5) step("R1 post", 0, 0, 0, 1, 8'(p), 8'(p));

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule